// File: doc/BRIEF.md
# Store Write Buffer with Drain Flag

This block sits between a write-through cache and the memory request port. Stores from the CPU are taken into a short first-in first-out queue so the CPU can move on at once, and the queued stores go out to memory oldest first, one per accepted memory request. Each slot holds a word address, a data word and per-byte enables. A level output reports that nothing is left in the queue. Software polls it to flush the buffer and wait before timing-sensitive device accesses.

Two configuration inputs set the policy. The first decides what happens to a CPU read while stores are queued. The read either waits until the queue is empty, or goes to memory ahead of the queued stores. In that second case a read whose word address is still queued waits until that entry has left. The second input allows a store to be folded into the newest queued entry when both address the same word. It is turned off for device register regions, where folding writes together would break the access sequence. The memory port uses a valid/ready handshake, and a request counts as taken in a cycle where both are high. Read data returns from memory outside this block.

Top module: `store_drain_fifo`

## Requirements
- R1: Stores go to memory as write requests (`memReqWrite`=1) strictly in the order they were accepted. Each request carries the stored word address, data and byte enables, after any folding allowed by R7.
- R2: With the default of four slots and memory not accepting, four stores to distinct words are accepted. `stReady` is then low for a further store that cannot fold, and stays low until a write is taken by memory.
- R3: `bufEmpty` is high exactly when no store is queued. It falls in the cycle after the first store is accepted and rises in the cycle after the last queued write is taken by memory. While it is high no write request is presented.
- R4: With `cfgReadBypass`=0 and any store queued, `rdReqReady` is low and queued writes keep draining. With the queue empty, a read is presented at once as a read request (`memReqWrite`=0, address `rdReqAddr`).
- R5: With `cfgReadBypass`=1 and no queued entry holding the read's word address, the read is presented to memory in the same cycle, ahead of the queued writes. `rdReqReady` follows `memReqReady`.
- R6: With `cfgReadBypass`=1 and a queued entry holding the read's word address, the read is held with `rdReqReady` low and the oldest write is presented instead, until no matching entry remains. The hazard check covers only entries queued before the current cycle.
- R7: With `cfgMergeEn`=1, a store whose word address equals the newest entry's address folds into it when at least two entries are queued. No slot is used, even when the queue is full. The enables become the OR of both, and lanes enabled by the new store take its bytes while the other lanes keep the old ones.
- R8: With `cfgMergeEn`=0, every accepted store takes its own slot and produces its own write request, even when it repeats the previous address.
- R9: The oldest entry, which is the one at the memory port, is never a fold target. When it is the only entry, a same-word store takes a new slot.
- R10: During and right after reset the queue is empty: `bufEmpty`=1, `memReqValid`=0 and `stReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgReadBypass | input | 1 | 1: reads may overtake queued writes; 0: reads wait for an empty queue |
| cfgMergeEn | input | 1 | 1: same-word stores fold into the newest entry |
| stValid | input | 1 | CPU store request valid |
| stReady | output | 1 | Store accepted when high together with stValid |
| stAddr | input | AW | Store word address |
| stData | input | DW | Store data word |
| stBe | input | DW/8 | Store byte enables, bit b covers data bits 8b+7..8b |
| rdReqValid | input | 1 | CPU read request valid |
| rdReqReady | output | 1 | Read request forwarded to memory this cycle |
| rdReqAddr | input | AW | Read word address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory takes the request |
| memReqWrite | output | 1 | 1: write from the queue head; 0: forwarded read |
| memReqAddr | output | AW | Memory request word address |
| memReqData | output | DW | Write data |
| memReqBe | output | DW/8 | Write byte enables (zero for reads) |
| bufEmpty | output | 1 | No store pending |

## Verification
The bench builds the block with the default depth of four, a 32-bit data word and a 12-bit address. Addresses are drawn from a pool of only four neighbouring words. This small pool makes same-word folds, read hazards against queued entries and full-queue stalls frequent under random traffic. All four combinations of the two policy inputs are run with memory acceptance rates from rare to always. Directed sequences cover the single-entry fold refusal and repeated stores with folding disabled.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  // Strobes from the control unit to the storage datapath.
  typedef struct packed {
    logic push;     // write incoming store into slot wrIdx
    logic merge;    // fold incoming store into slot newestIdx
    logic pop;      // head write taken by memory
    logic readSel;  // memory port carries the CPU read this cycle
  } sdf_strobe_t;

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgReadBypass,
  input  logic                     cfgMergeEn,
  input  logic                     stValid,
  output logic                     stReady,
  input  logic                     rdReqValid,
  output logic                     rdReqReady,
  input  logic                     memReqReady,
  output logic                     memReqValid,
  output logic                     memReqWrite,
  output logic                     bufEmpty,
  input  logic [DEPTH-1:0]         matchVec,
  input  logic                     newestHit,
  output sdf_strobe_t              ctl,
  output logic [$clog2(DEPTH)-1:0] wrIdx,
  output logic [$clog2(DEPTH)-1:0] newestIdx,
  output logic [$clog2(DEPTH)-1:0] headIdx,
  output logic [DEPTH-1:0]         validMask
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] headQ;
  logic [PW-1:0] tailQ;
  logic          hazard;
  logic          mergeOk;
  logic          readSel;

  function automatic logic [PW-1:0] incIdx(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] decIdx(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
  endfunction

  // Occupied slots: distance from head less than the fill count.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int off;
      off = (i + DEPTH - int'(headQ)) % DEPTH;
      validMask[i] = off < int'(cnt);
    end
  end

  assign wrIdx     = tailQ;
  assign newestIdx = decIdx(tailQ);
  assign headIdx   = headQ;

  assign hazard  = |matchVec;
  // The head sits at the memory port, so at least two entries are needed.
  assign mergeOk = cfgMergeEn && (cnt >= CW'(2)) && newestHit;
  assign readSel = rdReqValid && ((cnt == '0) || (cfgReadBypass && !hazard));

  assign stReady     = (cnt < CW'(DEPTH)) || mergeOk;
  assign memReqValid = readSel || (cnt != '0);
  assign memReqWrite = !readSel;
  assign rdReqReady  = readSel && memReqReady;
  assign bufEmpty    = (cnt == '0);

  always_comb begin
    ctl.readSel = readSel;
    ctl.merge   = stValid && mergeOk;
    ctl.push    = stValid && stReady && !mergeOk;
    ctl.pop     = !readSel && (cnt != '0) && memReqReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      headQ <= '0;
      tailQ <= '0;
    end else begin
      cnt <= cnt + CW'(ctl.push) - CW'(ctl.pop);
      if (ctl.push) tailQ <= incIdx(tailQ);
      if (ctl.pop)  headQ <= incIdx(headQ);
    end
  end

  // R2: fill level never exceeds the slot count.
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEPTH));

  // R2: a store taken while full must be a fold.
  p_full_takes_only_fold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady && cnt == CW'(DEPTH)) |-> ctl.merge);

  // R4: no read forwarded while stores wait and bypass is off.
  p_read_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgReadBypass && cnt != '0) |-> !rdReqReady);

  // R6: a forwarded read never matches a queued entry.
  p_no_stale_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && rdReqReady) |-> (matchVec == '0));

  // R7: a fold leaves the fill level alone.
  p_fold_keeps_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.merge && !ctl.pop) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sdf_strobe_t              ctl,
  input  logic [$clog2(DEPTH)-1:0] wrIdx,
  input  logic [$clog2(DEPTH)-1:0] newestIdx,
  input  logic [$clog2(DEPTH)-1:0] headIdx,
  input  logic [DEPTH-1:0]         validMask,
  input  logic [AW-1:0]            stAddr,
  input  logic [DW-1:0]            stData,
  input  logic [DW/8-1:0]          stBe,
  input  logic [AW-1:0]            rdReqAddr,
  output logic [AW-1:0]            memReqAddr,
  output logic [DW-1:0]            memReqData,
  output logic [DW/8-1:0]          memReqBe,
  output logic [DEPTH-1:0]         matchVec,
  output logic                     newestHit
);

  localparam int BW = DW / 8;
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] addrMem [DEPTH];
  logic [DW-1:0] dataMem [DEPTH];
  logic [BW-1:0] beMem   [DEPTH];
  logic [DW-1:0] newestData;
  logic [DW-1:0] foldWord;

  assign newestData = dataMem[newestIdx];

  // Per-lane fold: newer enabled bytes replace older ones.
  for (genvar b = 0; b < BW; b++) begin : g_lane
    assign foldWord[b*8 +: 8] = stBe[b] ? stData[b*8 +: 8] : newestData[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (ctl.push && wrIdx == PW'(e)) begin
        addrMem[e] <= stAddr;
        dataMem[e] <= stData;
        beMem[e]   <= stBe;
      end else if (ctl.merge && newestIdx == PW'(e)) begin
        dataMem[e] <= foldWord;
        beMem[e]   <= beMem[e] | stBe;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      matchVec[i] = validMask[i] && (addrMem[i] == rdReqAddr);
    end
  end

  assign newestHit  = (addrMem[newestIdx] == stAddr);
  assign memReqAddr = ctl.readSel ? rdReqAddr : addrMem[headIdx];
  assign memReqData = dataMem[headIdx];
  assign memReqBe   = ctl.readSel ? '0 : beMem[headIdx];

  // R9: the slot at the memory port is never folded into.
  p_fold_not_oldest_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.merge |-> (newestIdx != headIdx));

  // R7: a store either folds or takes a slot, never both.
  p_push_or_fold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.merge && ctl.push));

endmodule

// File: rtl/store_drain_fifo.sv
module store_drain_fifo
  import sdf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 30,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgReadBypass,
  input  logic            cfgMergeEn,
  input  logic            stValid,
  output logic            stReady,
  input  logic [AW-1:0]   stAddr,
  input  logic [DW-1:0]   stData,
  input  logic [DW/8-1:0] stBe,
  input  logic            rdReqValid,
  output logic            rdReqReady,
  input  logic [AW-1:0]   rdReqAddr,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [AW-1:0]   memReqAddr,
  output logic [DW-1:0]   memReqData,
  output logic [DW/8-1:0] memReqBe,
  output logic            bufEmpty
);

  localparam int PW = $clog2(DEPTH);

  sdf_strobe_t      ctl;
  logic [PW-1:0]    wrIdx;
  logic [PW-1:0]    newestIdx;
  logic [PW-1:0]    headIdx;
  logic [DEPTH-1:0] validMask;
  logic [DEPTH-1:0] matchVec;
  logic             newestHit;

  sdf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgReadBypass(cfgReadBypass), .cfgMergeEn(cfgMergeEn),
    .stValid(stValid), .stReady(stReady),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady),
    .memReqReady(memReqReady), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .bufEmpty(bufEmpty),
    .matchVec(matchVec), .newestHit(newestHit), .ctl(ctl),
    .wrIdx(wrIdx), .newestIdx(newestIdx), .headIdx(headIdx),
    .validMask(validMask)
  );

  sdf_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrIdx(wrIdx), .newestIdx(newestIdx), .headIdx(headIdx),
    .validMask(validMask),
    .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .rdReqAddr(rdReqAddr),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqBe(memReqBe),
    .matchVec(matchVec), .newestHit(newestHit)
  );

  // R3: an empty queue presents no write.
  p_empty_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> !(memReqValid && memReqWrite));

  // R3: a taken store clears the empty flag on the next cycle.
  p_store_clears_empty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady) |=> !bufEmpty);

  // R5: with bypass on and no hazard, a waiting read is presented.
  p_bypass_presents_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReadBypass && rdReqValid && matchVec == '0) |-> (memReqValid && !memReqWrite));

endmodule

// File: tb/test_store_drain_fifo.sv
module test_store_drain_fifo;

  localparam int DEPTH = 4;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int BW    = DW / 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgReadBypass, cfgMergeEn;
  logic          stValid, stReady;
  logic [AW-1:0] stAddr;
  logic [DW-1:0] stData;
  logic [BW-1:0] stBe;
  logic          rdReqValid, rdReqReady;
  logic [AW-1:0] rdReqAddr;
  logic          memReqValid, memReqReady, memReqWrite;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] memReqData;
  logic [BW-1:0] memReqBe;
  logic          bufEmpty;

  always #5 clk = ~clk;

  store_drain_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_drain_fifo (
    .clk(clk), .rstN(rstN), .cfgReadBypass(cfgReadBypass), .cfgMergeEn(cfgMergeEn),
    .stValid(stValid), .stReady(stReady), .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqBe(memReqBe),
    .bufEmpty(bufEmpty)
  );

  int errors = 0;
  int checks = 0;

  // Reference queue: index 0 is the oldest entry.
  logic [AW-1:0] qA [DEPTH];
  logic [DW-1:0] qD [DEPTH];
  logic [BW-1:0] qB [DEPTH];
  string         qT [DEPTH];
  int            qn = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] foldBytes(input logic [DW-1:0] oldD,
                                              input logic [DW-1:0] newD,
                                              input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int b = 0; b < BW; b++) r[b*8 +: 8] = be[b] ? newD[b*8 +: 8] : oldD[b*8 +: 8];
    return r;
  endfunction

  // One cycle: drive at the falling edge, check before the rising edge, update model.
  task automatic cyc(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                     input logic [BW-1:0] sb, input bit rv, input logic [AW-1:0] ra,
                     input bit mr);
    bit    match, readGo, expV, expMerge, expRdy, stH, popH;
    string tag;
    @(negedge clk);
    stValid = sv; stAddr = sa; stData = sd; stBe = sb;
    rdReqValid = rv; rdReqAddr = ra; memReqReady = mr;
    #2;
    match = 1'b0;
    for (int i = 0; i < qn; i++) if (qA[i] == ra) match = 1'b1;
    readGo   = rv && (qn == 0 || (cfgReadBypass && !match));
    expV     = readGo || (qn != 0);
    expMerge = cfgMergeEn && qn >= 2 && sa == qA[qn-1];
    expRdy   = (qn < DEPTH) || expMerge;

    chk(bufEmpty == (qn == 0), "R3", "bufEmpty", 64'(bufEmpty), 64'(qn == 0));
    chk(memReqValid == expV, readGo ? "R5" : "R1", "memReqValid", 64'(memReqValid), 64'(expV));
    if (readGo) begin
      tag = (qn == 0) ? "R4" : "R5";
      chk(memReqWrite == 1'b0, tag, "read memReqWrite", 64'(memReqWrite), 64'd0);
      chk(memReqAddr == ra, tag, "read memReqAddr", 64'(memReqAddr), 64'(ra));
    end else if (qn != 0) begin
      chk(memReqWrite == 1'b1, qT[0], "write memReqWrite", 64'(memReqWrite), 64'd1);
      chk(memReqAddr == qA[0], qT[0], "write memReqAddr", 64'(memReqAddr), 64'(qA[0]));
      chk(memReqData == qD[0], qT[0], "write memReqData", 64'(memReqData), 64'(qD[0]));
      chk(memReqBe == qB[0], qT[0], "write memReqBe", 64'(memReqBe), 64'(qB[0]));
    end
    if (rv) begin
      tag = (qn == 0) ? "R4" : (!cfgReadBypass ? "R4" : (match ? "R6" : "R5"));
      chk(rdReqReady == (readGo && mr), tag, "rdReqReady", 64'(rdReqReady), 64'(readGo && mr));
    end
    if (sv) begin
      tag = expMerge ? "R7" : ((qn == DEPTH) ? "R2" : "R1");
      chk(stReady == expRdy, tag, "stReady", 64'(stReady), 64'(expRdy));
    end

    stH  = sv && expRdy;
    popH = !readGo && qn != 0 && mr;
    @(posedge clk);
    if (stH && expMerge) begin
      qD[qn-1] = foldBytes(qD[qn-1], sd, sb);
      qB[qn-1] = qB[qn-1] | sb;
      qT[qn-1] = "R7";
    end
    if (popH) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        qA[i] = qA[i+1]; qD[i] = qD[i+1]; qB[i] = qB[i+1]; qT[i] = qT[i+1];
      end
      qn--;
    end
    if (stH && !expMerge) begin
      if (qn > 0 && qA[qn-1] == sa) tag = cfgMergeEn ? "R9" : "R8";
      else tag = "R1";
      qA[qn] = sa; qD[qn] = sd; qB[qn] = sb; qT[qn] = tag;
      qn++;
    end
  endtask

  task automatic idle(input bit mr);
    cyc(1'b0, '0, '0, '0, 1'b0, '0, mr);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [AW-1:0] pool [4];
    void'($urandom(32'd1234));
    pool[0] = 12'h040; pool[1] = 12'h041; pool[2] = 12'h042; pool[3] = 12'h043;
    rstN = 1'b0; cfgReadBypass = 1'b0; cfgMergeEn = 1'b0;
    stValid = 1'b0; stAddr = '0; stData = '0; stBe = '0;
    rdReqValid = 1'b0; rdReqAddr = '0; memReqReady = 1'b0;

    // R10: reset state
    repeat (2) @(negedge clk);
    #2;
    chk(bufEmpty == 1'b1, "R10", "bufEmpty in reset", 64'(bufEmpty), 64'd1);
    chk(memReqValid == 1'b0, "R10", "memReqValid in reset", 64'(memReqValid), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk(bufEmpty == 1'b1, "R10", "bufEmpty after reset", 64'(bufEmpty), 64'd1);
    chk(memReqValid == 1'b0, "R10", "memReqValid after reset", 64'(memReqValid), 64'd0);
    chk(stReady == 1'b1, "R10", "stReady after reset", 64'(stReady), 64'd1);

    // R2: fill with memory stalled, then stall the fifth store
    for (int k = 0; k < 6; k++)
      cyc(1'b1, pool[k % 4] + AW'(k / 4) * AW'(16), $urandom, 4'hF, 1'b0, '0, 1'b0);
    for (int k = 0; k < 8; k++) idle(1'b1);

    // R8: repeated word with folding disabled
    cyc(1'b1, pool[1], 32'h11111111, 4'h3, 1'b0, '0, 1'b0);
    cyc(1'b1, pool[1], 32'h22222222, 4'hC, 1'b0, '0, 1'b0);
    cyc(1'b1, pool[1], 32'h33333333, 4'h1, 1'b0, '0, 1'b0);
    for (int k = 0; k < 5; k++) idle(1'b1);

    // R9 then R7: single entry refuses a fold, second entry accepts it
    cfgMergeEn = 1'b1;
    cyc(1'b1, pool[2], 32'hAAAAAAAA, 4'hF, 1'b0, '0, 1'b0);
    cyc(1'b1, pool[2], 32'hBBBBBBBB, 4'h1, 1'b0, '0, 1'b0);
    cyc(1'b1, pool[2], 32'hCCCCCCCC, 4'h4, 1'b0, '0, 1'b0);
    for (int k = 0; k < 4; k++) idle(1'b1);

    // R6: read of a queued word waits; R5: other word overtakes
    cfgReadBypass = 1'b1; cfgMergeEn = 1'b0;
    cyc(1'b1, pool[3], 32'h5A5A5A5A, 4'hF, 1'b0, '0, 1'b0);
    cyc(1'b0, '0, '0, '0, 1'b1, pool[3], 1'b1);
    cyc(1'b0, '0, '0, '0, 1'b1, pool[3], 1'b1);
    cyc(1'b1, pool[0], 32'h0F0F0F0F, 4'hF, 1'b0, '0, 1'b0);
    cyc(1'b0, '0, '0, '0, 1'b1, pool[1], 1'b1);
    for (int k = 0; k < 3; k++) idle(1'b1);

    // Random traffic under every policy combination
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfgReadBypass = cfg[0];
      cfgMergeEn    = cfg[1];
      for (int n = 0; n < 1500; n++) begin
        int rate;
        rate = (n < 500) ? 20 : ((n < 1000) ? 60 : 100);
        cyc($urandom_range(99) < 60, pool[$urandom_range(3)], $urandom,
            BW'($urandom_range(1, 15)), $urandom_range(99) < 30,
            pool[$urandom_range(3)], $urandom_range(99) < rate);
      end
      for (int k = 0; k < 8; k++) idle(1'b1);
    end

    finish_run();
  end

endmodule